// File: doc/BRIEF.md
# Data Cache Line Coherence-State Controller

This block decides what happens to a single data cache line on each processor access. For every access it receives the line's stored four-state coherence value (Invalid, Shared, Exclusive, Modified), the direction of the access, a hit flag, and the attribute signals presented with it. From these it chooses the bus work to do and the state the line takes afterwards. The bus work is one of four things: none, a single read, a single write, or a full line fill.

The attributes are four inputs:
- the processor's cacheable request;
- the system's line-enable answer;
- the page writethrough bit;
- the system's writeback/writethrough choice.

It also takes a write-allocate permission flag, which is worked out elsewhere.

Bus work is handed to a bus agent through a request/done handshake. The new line state is committed only when the final transfer completes. A one-cycle `done` pulse reports the end of the access, together with a flag that says whether the cache data array must be written. The tag and data arrays, snooping and replacement stay outside the block.

Top module: `dcache_line_ctrl`

## Requirements
- R1: An access counts as a hit only when `acc_hit` is 1 and `acc_state` is not Invalid. States are encoded I=00, S=01, E=10, M=11. A read hit makes no bus request. `done` pulses in the cycle after acceptance, and `line_state` equals `acc_state`.
- R2: A read miss with `cache_en`=0 or `ken`=0 issues one single read (`bus_act`=01), and the line ends Invalid. Bus action codes are none=00, single read=01, single write=10, line fill=11.
- R3: A read miss with `cache_en`=1 and `ken`=1 issues one line fill (`bus_act`=11) with `bus_bytes` equal to LINE_BYTES.
- R4: After a read fill, the line becomes Exclusive when `pwt`=0 and `wb_mode`=1, and Shared otherwise.
- R5: A write hit to an Exclusive or Modified line makes no bus request. The line ends Modified and `cache_wr` is 1 with `done`.
- R6: A write hit to a Shared line issues one single write and asserts `cache_wr`. The line ends Exclusive when `pwt`=0 and `wb_mode`=1, and Shared otherwise.
- R7: A write miss with `wr_alloc`=0 issues one single write, leaves the line Invalid, and keeps `cache_wr` at 0.
- R8: A write miss with `wr_alloc`=1 in writeback mode (`pwt`=0, `wb_mode`=1) issues one line fill. The line ends Modified with `cache_wr`=1.
- R9: A write miss with `wr_alloc`=1 in writethrough mode issues a line fill followed by a single write as a second request. The line ends Shared with `cache_wr`=1.
- R10: During a single read or write, `bus_bytes` equals the `acc_bytes` captured at acceptance, which lies in 1 to MAX_SINGLE.
- R11: An access is accepted only while `busy` is 0, and `acc_valid` during `busy` is ignored. `line_state` holds its old value until the last `bus_done`. `bus_req` and `bus_act` stay stable until `bus_done`.
- R12: After reset, `line_state` is Invalid, and `busy`, `bus_req`, `done` and `cache_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access presented |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_hit | input | 1 | Tag match |
| acc_state | input | 2 | Stored line state |
| acc_bytes | input | SW | Single-transfer size, 1..MAX_SINGLE |
| cache_en | input | 1 | Processor requests a cacheable access |
| ken | input | 1 | System grants line caching |
| pwt | input | 1 | Page writethrough bit |
| wb_mode | input | 1 | 1 = system allows writeback |
| wr_alloc | input | 1 | Write allocation permitted |
| busy | output | 1 | Access in progress |
| bus_req | output | 1 | Bus transfer requested |
| bus_act | output | 2 | Bus action code |
| bus_bytes | output | LW | Bytes in the requested transfer |
| bus_done | input | 1 | Bus agent finished the transfer |
| done | output | 1 | Access complete pulse |
| cache_wr | output | 1 | Write data into the cache (valid with done) |
| line_state | output | 2 | Committed line state |

## Verification
The bench builds the block with its defaults: a 32-byte line and single transfers of up to 8 bytes. This makes the fill length distinguishable from every legal single size, so a swapped byte count is visible. The bus agent in the bench answers after 0 to 3 cycles. That range covers a completion in the same cycle the request appears, as well as the two-request writethrough allocate path. Directed corners come first, including a hit flagged on an Invalid line. Seeded random attribute mixes then cover every combination of hit, state, cacheability and mode.

// File: rtl/dcache_line_ctrl.sv
module dcache_line_ctrl #(
  parameter int LINE_BYTES = 32,
  parameter int MAX_SINGLE = 8,
  localparam int LW = $clog2(LINE_BYTES + 1),
  localparam int SW = $clog2(MAX_SINGLE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic          acc_hit,
  input  logic [1:0]    acc_state,
  input  logic [SW-1:0] acc_bytes,
  input  logic          cache_en,
  input  logic          ken,
  input  logic          pwt,
  input  logic          wb_mode,
  input  logic          wr_alloc,
  output logic          busy,
  output logic          bus_req,
  output logic [1:0]    bus_act,
  output logic [LW-1:0] bus_bytes,
  input  logic          bus_done,
  output logic          done,
  output logic          cache_wr,
  output logic [1:0]    line_state
);
  localparam logic [1:0] ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11;
  localparam logic [1:0] A_NONE = 2'b00, A_RD = 2'b01, A_WR = 2'b10, A_FILL = 2'b11;

  typedef enum logic [1:0] {IDLE, XFER1, XFER2} phase_t;
  phase_t phase;

  logic [1:0]    act_q, nxt_q;
  logic          second_q, cwr_q;
  logic [SW-1:0] bytes_q;

  wire is_hit    = acc_hit && (acc_state != ST_I);
  wire writeback = !pwt && wb_mode;
  wire cacheable = cache_en && ken;
  wire accept    = acc_valid && (phase == IDLE);

  logic [1:0] d_act, d_nxt;
  logic       d_second, d_cwr;

  always_comb begin
    d_second = 1'b0;
    d_cwr    = 1'b0;
    if (!acc_write) begin
      if (is_hit) begin
        d_act = A_NONE; d_nxt = acc_state;
      end else if (cacheable) begin
        d_act = A_FILL; d_nxt = writeback ? ST_E : ST_S;
      end else begin
        d_act = A_RD;   d_nxt = ST_I;
      end
    end else if (is_hit) begin
      d_cwr = 1'b1;
      if (acc_state == ST_S) begin
        d_act = A_WR;   d_nxt = writeback ? ST_E : ST_S;
      end else begin
        d_act = A_NONE; d_nxt = ST_M;
      end
    end else if (wr_alloc) begin
      d_cwr = 1'b1;
      d_act = A_FILL;
      d_nxt = writeback ? ST_M : ST_S;
      d_second = !writeback;
    end else begin
      d_act = A_WR;     d_nxt = ST_I;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= IDLE;
      act_q      <= A_NONE;
      nxt_q      <= ST_I;
      second_q   <= 1'b0;
      cwr_q      <= 1'b0;
      bytes_q    <= '0;
      done       <= 1'b0;
      line_state <= ST_I;
    end else begin
      done <= 1'b0;
      case (phase)
        IDLE: if (accept) begin
          act_q    <= d_act;
          nxt_q    <= d_nxt;
          second_q <= d_second;
          cwr_q    <= d_cwr;
          bytes_q  <= acc_bytes;
          if (d_act == A_NONE) begin
            done       <= 1'b1;
            line_state <= d_nxt;
          end else begin
            phase <= XFER1;
          end
        end
        XFER1: if (bus_done) begin
          if (second_q) begin
            phase <= XFER2;
          end else begin
            phase      <= IDLE;
            done       <= 1'b1;
            line_state <= nxt_q;
          end
        end
        XFER2: if (bus_done) begin
          phase      <= IDLE;
          done       <= 1'b1;
          line_state <= nxt_q;
        end
        default: phase <= IDLE;
      endcase
    end
  end

  assign busy      = (phase != IDLE);
  assign bus_req   = busy;
  assign bus_act   = (phase == XFER2) ? A_WR : (busy ? act_q : A_NONE);
  assign cache_wr  = done && cwr_q;
  assign bus_bytes = (bus_act == A_FILL) ? LW'(LINE_BYTES) : LW'(bytes_q);

  a_r1_read_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !busy && !acc_write && acc_hit && acc_state != ST_I)
      |=> (done && !bus_req && line_state == $past(acc_state)));

  a_r2_single_read_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_act == A_RD && bus_done) |=> (done && line_state == ST_I));

  a_r3_fill_length: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_act == A_FILL) |-> (bus_bytes == LW'(LINE_BYTES)));

  a_r10_single_length: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_act != A_FILL) |-> (bus_bytes != '0 && bus_bytes <= LW'(MAX_SINGLE)));

  a_r11_state_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_done) |=> $stable(line_state));

  a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_act)));

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_dcache_line_ctrl.sv
module tb_dcache_line_ctrl;
  localparam int LINE_BYTES = 32;
  localparam int MAX_SINGLE = 8;
  localparam int LW = $clog2(LINE_BYTES + 1);
  localparam int SW = $clog2(MAX_SINGLE + 1);

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, acc_hit = 0;
  logic [1:0] acc_state = 0;
  logic [SW-1:0] acc_bytes = 1;
  logic cache_en = 0, ken = 0, pwt = 0, wb_mode = 0, wr_alloc = 0;
  logic busy, bus_req, done, cache_wr, bus_done = 0;
  logic [1:0] bus_act, line_state;
  logic [LW-1:0] bus_bytes;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dcache_line_ctrl #(.LINE_BYTES(LINE_BYTES), .MAX_SINGLE(MAX_SINGLE)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_hit(acc_hit), .acc_state(acc_state), .acc_bytes(acc_bytes),
    .cache_en(cache_en), .ken(ken), .pwt(pwt), .wb_mode(wb_mode),
    .wr_alloc(wr_alloc), .busy(busy), .bus_req(bus_req), .bus_act(bus_act),
    .bus_bytes(bus_bytes), .bus_done(bus_done), .done(done),
    .cache_wr(cache_wr), .line_state(line_state));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input logic w, input logic h, input logic [1:0] s,
      input logic ce, input logic k, input logic p, input logic wb, input logic al,
      output int n, output int a0, output int a1, output int ns, output int cw,
      output string req);
    logic hit = h && s != 2'b00;
    logic wbk = !p && wb;
    n = 0; a0 = 0; a1 = 0; cw = 0;
    if (!w) begin
      if (hit) begin ns = s; req = "R1"; end
      else if (ce && k) begin n = 1; a0 = 3; ns = wbk ? 2 : 1; req = "R3/R4"; end
      else begin n = 1; a0 = 1; ns = 0; req = "R2"; end
    end else if (hit) begin
      cw = 1;
      if (s == 2'b01) begin n = 1; a0 = 2; ns = wbk ? 2 : 1; req = "R6"; end
      else begin ns = 3; req = "R5"; end
    end else if (al) begin
      cw = 1; n = wbk ? 1 : 2; a0 = 3; a1 = 2; ns = wbk ? 3 : 1;
      req = wbk ? "R8" : "R9";
    end else begin n = 1; a0 = 2; ns = 0; req = "R7"; end
  endfunction

  task automatic run(input logic w, input logic h, input logic [1:0] s,
      input logic ce, input logic k, input logic p, input logic wb, input logic al,
      input int nb, input int dly);
    int n, a0, a1, ns, cw, got, prev;
    int acts[2];
    int byts[2];
    string req;
    model(w, h, s, ce, k, p, wb, al, n, a0, a1, ns, cw, req);
    prev = line_state;
    got = 0;
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_hit = h; acc_state = s; acc_bytes = SW'(nb);
    cache_en = ce; ken = k; pwt = p; wb_mode = wb; wr_alloc = al;
    @(negedge clk);
    acc_valid = 0;
    for (int cyc = 0; cyc < 40 && !done; cyc++) begin
      if (bus_req) begin
        if (got < 2) begin acts[got] = bus_act; byts[got] = bus_bytes; end
        got++;
        acc_valid = 1; acc_write = ~w; acc_hit = 1; acc_state = 2'b11;
        for (int d = 0; d < dly; d++) begin
          @(negedge clk);
          chk("R11 state held", line_state, prev);
        end
        bus_done = 1;
        @(negedge clk);
        bus_done = 0; acc_valid = 0;
      end else begin
        @(negedge clk);
      end
    end
    chk({req, " done"}, done, 1);
    chk({req, " transfers"}, got, n);
    if (n > 0 && got > 0) begin
      chk({req, " first act"}, acts[0], a0);
      chk({req, " first bytes R10"}, byts[0], (a0 == 3) ? LINE_BYTES : nb);
    end
    if (n > 1 && got > 1) begin
      chk({req, " second act"}, acts[1], a1);
      chk({req, " second bytes R10"}, byts[1], nb);
    end
    chk({req, " state"}, line_state, ns);
    chk({req, " cache_wr"}, cache_wr, cw);
    @(negedge clk);
    chk("R11 no extra access", {busy, done}, 0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R12 state", line_state, 0);
    chk("R12 busy/req", {busy, bus_req}, 0);
    chk("R12 done/cache_wr", {done, cache_wr}, 0);
    rst_n = 1;
    run(0, 1, 2'b10, 1, 1, 0, 1, 0, 4, 1);
    run(0, 1, 2'b00, 1, 1, 0, 1, 0, 3, 0);
    run(0, 0, 2'b00, 0, 1, 0, 1, 0, 8, 2);
    run(0, 0, 2'b00, 1, 0, 0, 1, 0, 1, 0);
    run(0, 0, 2'b00, 1, 1, 0, 1, 0, 2, 3);
    run(0, 0, 2'b00, 1, 1, 1, 1, 0, 2, 1);
    run(1, 1, 2'b10, 0, 0, 0, 0, 0, 5, 0);
    run(1, 1, 2'b11, 0, 0, 1, 0, 0, 5, 0);
    run(1, 1, 2'b01, 0, 0, 0, 1, 0, 6, 2);
    run(1, 1, 2'b01, 0, 0, 0, 0, 0, 7, 1);
    run(1, 0, 2'b00, 0, 0, 0, 1, 0, 1, 1);
    run(1, 0, 2'b00, 0, 0, 0, 1, 1, 4, 2);
    run(1, 0, 2'b00, 0, 0, 1, 1, 1, 8, 3);
    run(1, 0, 2'b00, 0, 0, 0, 0, 1, 3, 0);
    for (int i = 0; i < 300; i++) begin
      logic [7:0] r = 8'($urandom);
      run(r[0], r[1], 2'($urandom), r[2], r[3], r[4], r[5], r[6],
          1 + int'($urandom % MAX_SINGLE), int'($urandom % 4));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule